// File: doc/BRIEF.md
# Fractional Sync Interval Block Generator

This block turns a bare stream of sample strobes into a block-framed stream. Every group of `cfg_blk_len` valid samples forms one block. The generator marks the first sample of each block with a start flag and the last sample with an end flag. It also attaches a block sequence number (BSN) to every sample. The BSN counts whole blocks from an absolute epoch and can be loaded with a timestamp. Only valid samples are counted, so gaps in the input stream do not move the block grid.

The generator also produces a once-per-second sync marker. It raises sync on the first block that begins at or after each one-second boundary, where one second is `cfg_sps` valid samples of this stream. The samples per second need not be a whole multiple of the block length. The number of blocks between two syncs is therefore either the floor or the ceiling of `cfg_sps / cfg_blk_len`, in an exact repeating pattern. At 200 M samples/s, 1024-sample blocks alternate between 195312 and 195313 per second. With 864-sample blocks, 13 extra blocks fall in every 27 seconds. An exact remainder accumulator tracks the sub-block phase of the second boundary, so the sync never drifts.

A one-cycle `start_i` pulse loads the BSN and captures the block length and the samples-per-second value. It also zeroes the phase, so the next sample starts a block that carries sync.

The controller has three states:
- `S_IDLE`: after reset, nothing is forwarded.
- `S_HEAD`: the next valid sample opens a block.
- `S_BODY`: inside a block.

Its transitions are:
- start, from any state, goes to `S_HEAD`.
- `S_HEAD` goes to `S_BODY` on a valid sample when the block has more than one sample. It stays in `S_HEAD` when the block length is 1.
- `S_BODY` returns to `S_HEAD` on the valid sample that closes the block.
- `S_IDLE` waits for start.

Top module: `frac_sync_blkgen`

## Requirements
- R1: After reset, and until the first `start_i`, all outputs are 0 whatever `in_valid` does.
- R2: Once started, `out_valid` is `in_valid` delayed by one clock. A sample presented in the same cycle as `start_i` is dropped.
- R3: `out_sop` is 1 on the first valid sample of each block and `out_eop` is 1 on the `cfg_blk_len`-th. Both are 0 on non-valid cycles, and with a block length of 1 every sample carries both.
- R4: Block framing and sync placement count valid samples only. Idle cycles between samples change neither.
- R5: `out_bsn` equals the loaded start BSN throughout the first block and rises by one per block, wrapping at 2^BSN_W. On cycles with `out_valid` at 0 it holds its last value.
- R6: The first block after every `start_i` carries `out_sync`.
- R7: Number the blocks k = 0, 1, ... from start, with block length M and S samples per second. Block k > 0 carries `out_sync` exactly when floor(k·M/S) > floor((k−1)·M/S). `out_sync` only appears together with `out_sop`.
- R8: A `start_i` in the middle of a block abandons that block. The next valid sample opens a new block with sync and the freshly loaded BSN.
- R9: `cfg_blk_len` and `cfg_sps` are sampled only in the `start_i` cycle. Changes at other times have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load BSN and configuration, restart the phase |
| start_bsn | input | BSN_W | BSN given to the first block after start |
| cfg_blk_len | input | LEN_W | Samples per block (1 or more, less than `cfg_sps`) |
| cfg_sps | input | SPS_W | Valid samples per second for this stream |
| in_valid | input | 1 | Sample strobe |
| out_valid | output | 1 | Forwarded sample strobe |
| out_sop | output | 1 | First sample of a block |
| out_eop | output | 1 | Last sample of a block |
| out_sync | output | 1 | Block is the first to start in a new second |
| out_bsn | output | BSN_W | Block sequence number of the current sample |

## Verification
The main function is driven with several ratios of samples per second to block length:
- 10/4 gives an alternating 3,2 sync pattern.
- 67/27 scales down the 27-second oversampled pattern and must show 27 syncs in 67 blocks.
- 2560/1024 uses a realistic block length.
- 7/3 and 3/1 cover a restart and single-sample blocks.

Running the 67/27 ratio with random gaps separates counting valid samples from counting clocks. A restart mid-block with a sample in the start cycle separates a true restart from a continued block. Changing the configuration while the generator runs separates sampling at start from tracking the live inputs. Loading a BSN just below a 32-bit carry exposes a narrowed counter.

// File: rtl/fsbg_pkg.sv
package fsbg_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HEAD = 2'd1,
        S_BODY = 2'd2
    } fsm_t;

endpackage

// File: rtl/fsbg_pos_cnt.sv
// Sample position inside the current block.
module fsbg_pos_cnt #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [LEN_W-1:0] len,
    output logic             last
);

    logic [LEN_W-1:0] pos_q;

    always_comb begin
        last = (pos_q == (len - LEN_W'(1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clr) begin
            pos_q <= '0;
        end else if (adv) begin
            pos_q <= last ? '0 : pos_q + LEN_W'(1);
        end
    end

endmodule

// File: rtl/fsbg_phase_acc.sv
// Remainder of block starts modulo one second; flags the next block as sync.
module fsbg_phase_acc #(
    parameter int SPS_W = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             blk_end,
    input  logic [LEN_W-1:0] len,
    input  logic [SPS_W-1:0] sps,
    output logic             sync_pend
);

    localparam int ACC_W = SPS_W + 1;

    logic [SPS_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    always_comb begin
        sum  = ACC_W'(acc_q) + ACC_W'(len);
        wrap = (sum >= ACC_W'(sps));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            sync_pend <= 1'b0;
        end else if (clr) begin
            acc_q     <= '0;
            sync_pend <= 1'b1;
        end else if (blk_end) begin
            acc_q     <= wrap ? SPS_W'(sum - ACC_W'(sps)) : SPS_W'(sum);
            sync_pend <= wrap;
        end
    end

endmodule

// File: rtl/fsbg_bsn_cnt.sv
// Loadable block sequence counter.
module fsbg_bsn_cnt #(
    parameter int BSN_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BSN_W-1:0] load_val,
    input  logic             inc,
    output logic [BSN_W-1:0] bsn
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsn <= '0;
        end else if (load) begin
            bsn <= load_val;
        end else if (inc) begin
            bsn <= bsn + BSN_W'(1);
        end
    end

endmodule

// File: rtl/frac_sync_blkgen.sv
module frac_sync_blkgen
    import fsbg_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int SPS_W = 32,
    parameter int BSN_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BSN_W-1:0] start_bsn,
    input  logic [LEN_W-1:0] cfg_blk_len,
    input  logic [SPS_W-1:0] cfg_sps,
    input  logic             in_valid,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output logic             out_sync,
    output logic [BSN_W-1:0] out_bsn
);

    fsm_t             state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic [SPS_W-1:0] sps_q;
    logic             fire, last, blk_end, sync_pend;
    logic [BSN_W-1:0] bsn_cur;

    always_comb begin
        fire    = in_valid && (state_q != S_IDLE) && !start_i;
        blk_end = fire && last;
    end

    // configuration captured only at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LEN_W'(1);
            sps_q <= SPS_W'(1);
        end else if (start_i) begin
            len_q <= cfg_blk_len;
            sps_q <= cfg_sps;
        end
    end

    fsbg_pos_cnt #(.LEN_W(LEN_W)) pos_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_i),
        .adv   (fire),
        .len   (len_q),
        .last  (last)
    );

    fsbg_phase_acc #(.SPS_W(SPS_W), .LEN_W(LEN_W)) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_i),
        .blk_end   (blk_end),
        .len       (len_q),
        .sps       (sps_q),
        .sync_pend (sync_pend)
    );

    fsbg_bsn_cnt #(.BSN_W(BSN_W)) bsn_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_i),
        .load_val (start_bsn),
        .inc      (blk_end),
        .bsn      (bsn_cur)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = S_HEAD;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_HEAD: if (fire) state_d = last ? S_HEAD : S_BODY;
                S_BODY: if (blk_end) state_d = S_HEAD;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_sync  <= 1'b0;
            out_bsn   <= '0;
        end else begin
            out_valid <= fire;
            out_sop   <= fire && (state_q == S_HEAD);
            out_eop   <= blk_end;
            out_sync  <= fire && (state_q == S_HEAD) && sync_pend;
            if (fire) begin
                out_bsn <= bsn_cur;
            end
        end
    end

endmodule

// File: rtl/fsbg_chk.sv
module fsbg_chk
    import fsbg_pkg::*;
#(
    parameter int BSN_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input fsm_t             state_q,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic             out_sync,
    input logic [BSN_W-1:0] out_bsn
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (start_i) begin
            armed_q <= 1'b1;
        end else if (out_sop) begin
            armed_q <= 1'b0;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> !out_valid);

    // R2
    start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !out_valid);

    // R3
    sop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

    // R3
    eop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> out_valid);

    // R5
    bsn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_bsn));

    // R6
    first_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && out_sop) |-> out_sync);

    // R7
    sync_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sync |-> out_sop);

endmodule

bind frac_sync_blkgen fsbg_chk #(.BSN_W(BSN_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .state_q   (state_q),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_sync  (out_sync),
    .out_bsn   (out_bsn)
);

// File: tb/frac_sync_blkgen_tb_top.sv
module frac_sync_blkgen_tb_top;

    localparam int LEN_W = 16;
    localparam int SPS_W = 32;
    localparam int BSN_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [BSN_W-1:0] start_bsn = '0;
    logic [LEN_W-1:0] cfg_blk_len = LEN_W'(4);
    logic [SPS_W-1:0] cfg_sps = SPS_W'(10);
    logic             in_valid = 1'b0;
    logic             out_valid, out_sop, out_eop, out_sync;
    logic [BSN_W-1:0] out_bsn;

    always #5 clk = ~clk;

    frac_sync_blkgen #(.LEN_W(LEN_W), .SPS_W(SPS_W), .BSN_W(BSN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_bsn(start_bsn),
        .cfg_blk_len(cfg_blk_len), .cfg_sps(cfg_sps), .in_valid(in_valid),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_sync(out_sync), .out_bsn(out_bsn)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: sample counting and second arithmetic
    bit          m_run = 1'b0;
    longint      m_pos, m_k, m_len, m_sps;
    logic [63:0] m_bsn;
    logic        e_valid = 0, e_sop = 0, e_eop = 0, e_sync = 0;
    logic [63:0] e_bsn = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0;
            e_valid = 0; e_sop = 0; e_eop = 0; e_sync = 0; e_bsn = '0;
        end else if (start_i) begin
            m_run = 1; m_pos = 0; m_k = 0;
            m_len = longint'(cfg_blk_len); m_sps = longint'(cfg_sps);
            m_bsn = start_bsn;
            e_valid = 0; e_sop = 0; e_eop = 0; e_sync = 0;
        end else if (m_run && in_valid) begin
            e_valid = 1;
            e_sop   = (m_pos == 0);
            e_eop   = (m_pos == m_len - 1);
            e_sync  = e_sop && ((m_k == 0) ||
                      ((m_k * m_len) / m_sps != ((m_k - 1) * m_len) / m_sps));
            e_bsn   = m_bsn;
            if (e_eop) begin
                m_pos = 0; m_k++; m_bsn = m_bsn + 64'd1;
            end else begin
                m_pos++;
            end
        end else begin
            e_valid = 0; e_sop = 0; e_eop = 0; e_sync = 0;
        end
    end

    // per-cycle comparison and block statistics
    int          n_blk = 0, n_sync = 0;
    bit          first_pend = 0;
    logic [63:0] first_exp_bsn = '0;
    logic [63:0] last_sop_bsn = '0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 out_valid", 64'(out_valid), 64'(e_valid));
            chk("R3 out_sop", 64'(out_sop), 64'(e_sop));
            chk("R3 out_eop", 64'(out_eop), 64'(e_eop));
            chk("R7 out_sync", 64'(out_sync), 64'(e_sync));
            chk("R5 out_bsn", out_bsn, e_bsn);
            if (out_valid && out_sop) begin
                n_blk++;
                if (out_sync) n_sync++;
                last_sop_bsn = out_bsn;
                if (first_pend) begin
                    chk("R6 sync on first block", 64'(out_sync), 64'd1);
                    chk("R8 first block bsn", out_bsn, first_exp_bsn);
                    first_pend = 0;
                end
            end
        end
    end

    logic [7:0] lfsr = 8'hA5;

    task automatic feed(input int n, input bit gaps);
        int sent = 0;
        while (sent < n) begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            in_valid = gaps ? (lfsr[0] | lfsr[2]) : 1'b1;
            if (in_valid) sent++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_start(input logic [63:0] bsn, input int len, input int sps, input bit v);
        @(negedge clk);
        start_i = 1'b1; start_bsn = bsn;
        cfg_blk_len = LEN_W'(len); cfg_sps = SPS_W'(sps);
        in_valid = v;
        first_pend = 1; first_exp_bsn = bsn;
        n_blk = 0; n_sync = 0;
        @(negedge clk);
        start_i = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: valid without start forwards nothing
        feed(6, 1'b0);
        chk("R1 idle out_valid", 64'(out_valid), 64'd0);
        chk("R1 idle out_bsn", out_bsn, 64'd0);

        // ratio 10/4: syncs at blocks 0,3,5,8,10,13,15,18
        do_start(64'd1000, 4, 10, 1'b0);
        feed(80, 1'b0);
        chk("R3 blocks 10/4", 64'(n_blk), 64'd20);
        chk("R7 syncs 10/4", 64'(n_sync), 64'd8);

        // R9: config change while running is ignored
        do_start(64'd5, 4, 10, 1'b0);
        feed(8, 1'b0);
        cfg_blk_len = LEN_W'(7); cfg_sps = SPS_W'(5);
        feed(72, 1'b0);
        chk("R9 blocks after cfg change", 64'(n_blk), 64'd20);
        chk("R9 syncs after cfg change", 64'(n_sync), 64'd8);

        // 67/27 with gaps: 27 syncs in 67 blocks, bsn over a 32-bit carry
        do_start(64'h0000_0000_FFFF_FFF0, 27, 67, 1'b0);
        feed(67 * 27, 1'b1);
        chk("R4 blocks with gaps", 64'(n_blk), 64'd67);
        chk("R4 syncs with gaps", 64'(n_sync), 64'd27);
        chk("R5 last bsn", last_sop_bsn, 64'h0000_0000_FFFF_FFF0 + 64'd66);

        // R8: restart mid-block, sample in start cycle dropped
        feed(6, 1'b0);
        do_start(64'd77, 3, 7, 1'b1);
        feed(21, 1'b0);
        chk("R8 blocks after restart", 64'(n_blk), 64'd7);
        chk("R8 syncs after restart", 64'(n_sync), 64'd3);

        // R3: single-sample blocks, syncs at 0,3,6
        do_start(64'd0, 1, 3, 1'b0);
        feed(9, 1'b1);
        chk("R3 blocks len 1", 64'(n_blk), 64'd9);
        chk("R7 syncs len 1", 64'(n_sync), 64'd3);

        // realistic block length, ratio 2.5: syncs at 0,3,5,8
        do_start(64'd123456789, 1024, 2560, 1'b0);
        feed(10240, 1'b0);
        chk("R7 blocks len 1024", 64'(n_blk), 64'd10);
        chk("R7 syncs len 1024", 64'(n_sync), 64'd4);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule